// File: doc/BRIEF.md
# QPSK Interpolating I/Q Modulator to Real IF

This block turns a stream of two-bit symbols into one real intermediate-frequency sample stream. Each accepted symbol is split into an in-phase and a quadrature sign, giving a point of fixed amplitude in each of the two rails. Each rail is raised to the output rate by zero insertion and then shaped by its own 60-tap root-raised-cosine interpolation filter. The two shaped rails are mixed onto a carrier whose cosine and sine samples arrive on input ports, and the result is rounded and clipped into a signed output word.

The output produces one sample on every clock, with no strobe. Symbols come in on a valid/ready port. `sym_ready` is high for one cycle in every `INTERP` cycles, and only that cycle can take a symbol. A symbol moves only when `sym_valid` and `sym_ready` are both high. The source may hold `sym_valid` high and change `sym_bits` for any length of time; nothing is taken while `sym_ready` is low. If `sym_valid` is low during a ready cycle, the block inserts a zero for that slot. The source is never stalled beyond that rhythm, and the output side applies no back-pressure.

Top module: `qpsk_if_modulator`

## Requirements
- R1: While `rst_n` is low, `if_out` is 0 and `sym_ready` is 1, and the filter history is cleared, so `if_out` stays 0 after reset until a symbol has been accepted.
- R2: An accepted symbol drives the in-phase rail from `sym_bits[0]` and the quadrature rail from `sym_bits[1]`. A bit value of 0 gives +AMP and a bit value of 1 gives -AMP (AMP = 511 by default).
- R3: Counting from reset, `sym_ready` is 1 in the first cycle and then in every INTERP-th cycle after it, and 0 in all other cycles. `sym_valid` and `sym_bits` have no effect in a cycle where `sym_ready` is 0.
- R4: Each clock pushes one sample per rail into the filter. That sample is the mapped symbol when a handshake occurs and 0 otherwise, so with no handshakes `if_out` decays to 0 and stays there.
- R5: Each rail is filtered as y = AMP·Σ c[k]·s[n−k] over 60 taps. The coefficient table is symmetric, with centre values 1750, 1410, 850, 250 moving outward.
- R6: `if_out` = sat(floor((I·cos − Q·sin + 2^(SHIFT−1)) / 2^SHIFT)). The products are exact, SHIFT is 16, and saturation is to [−32768, 32767].
- R7: A symbol accepted at clock edge k first affects `if_out` after edge k+2. That output uses the carrier samples present before edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one output sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Source has a symbol |
| sym_ready | output | 1 | Block can take a symbol this cycle |
| sym_bits | input | 2 | Bit 0 in-phase sign, bit 1 quadrature sign |
| car_cos | input | CRW (12) | Signed carrier cosine sample |
| car_sin | input | CRW (12) | Signed carrier sine sample |
| if_out | output | OW (16) | Signed real IF sample |

## Verification
The bench builds the block with its default parameters: interpolation by 4, 60 taps, AMP 511, 12-bit carrier and a shift of 16. A shift of 16 lets a run of equal symbols on a diagonal carrier drive `if_out` into both clip levels, and the bench confirms that this happens. A carrier at a quarter of the sample rate passes each rail alone through the mixer in turn, which exposes a swapped rail or a sign error. The bench also holds `sym_valid` high across the non-ready cycles while changing the bits, and a single isolated symbol exposes the filter's edge tap and the two-cycle latency.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

  localparam int HALF_TAPS = 30;

  // One half of a symmetric pulse-shaping response, index 0 at the centre.
  function automatic int half_coef(input int idx);
    case (idx)
      0:  return 1750;
      1:  return 1410;
      2:  return 850;
      3:  return 250;
      4:  return -195;
      5:  return -385;
      6:  return -325;
      7:  return -117;
      8:  return 103;
      9:  return 223;
      10: return 202;
      11: return 76;
      12: return -65;
      13: return -140;
      14: return -125;
      15: return -50;
      16: return 40;
      17: return 95;
      18: return 85;
      19: return 30;
      20: return -20;
      21: return -60;
      22: return -50;
      23: return -15;
      24: return 10;
      25: return 30;
      26: return 25;
      27: return 8;
      28: return -3;
      29: return -10;
      default: return 0;
    endcase
  endfunction

  // Mirror the half table across the centre of a taps-long line.
  function automatic int tap_coef(input int k, input int taps);
    int mid;
    int idx;
    mid = taps / 2;
    idx = (k < mid) ? (mid - 1 - k) : (k - mid);
    return half_coef(idx);
  endfunction

endpackage

// File: rtl/qmod_mapper.sv
module qmod_mapper #(
  parameter int INTERP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym_bits,
  output logic       i_nz,
  output logic       i_neg,
  output logic       q_nz,
  output logic       q_neg
);
  localparam int PHW = (INTERP > 1) ? $clog2(INTERP) : 1;

  logic [PHW-1:0] ph_q;
  logic           fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ph_q <= '0;
    else if (ph_q == PHW'(INTERP - 1))    ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign sym_ready = (ph_q == '0);
  assign fire      = sym_valid && sym_ready;
  assign i_nz      = fire;
  assign q_nz      = fire;
  assign i_neg     = sym_bits[0];
  assign q_neg     = sym_bits[1];

  // Checker: cycles spent without ready must stay below INTERP.
  logic [PHW:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (sym_ready)  gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  p_ready_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < (PHW+1)'(INTERP));

  generate
    if (INTERP > 1) begin : g_gap
      p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready |=> !sym_ready);
    end
  endgenerate

endmodule

// File: rtl/qmod_interp_fir.sv
module qmod_interp_fir #(
  parameter int TAPS = 60,
  parameter int CW   = 12,
  parameter int DW   = 10,
  parameter int AMP  = 511
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_nz,
  input  logic                                   in_neg,
  output logic signed [CW+$clog2(TAPS)+DW-1:0]   y_q
);
  localparam int SUMW = CW + $clog2(TAPS);
  localparam int FW   = SUMW + DW;
  localparam logic signed [DW-1:0] AMP_S = DW'(AMP);

  // Upsampled history as sign codes: nonzero flag plus negative flag.
  logic [TAPS-1:0]         nz_q;
  logic [TAPS-1:0]         neg_q;
  logic signed [SUMW-1:0]  csum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q  <= '0;
      neg_q <= '0;
    end else begin
      nz_q  <= {nz_q[TAPS-2:0],  in_nz};
      neg_q <= {neg_q[TAPS-2:0], in_neg};
    end
  end

  // Inputs are only +/-1 or 0, so each tap is an add, a subtract or nothing.
  always_comb begin
    csum = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (nz_q[k]) begin
        if (neg_q[k]) csum = csum - SUMW'(qmod_pkg::tap_coef(k, TAPS));
        else          csum = csum + SUMW'(qmod_pkg::tap_coef(k, TAPS));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= FW'(csum) * FW'(AMP_S);
  end

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_q == '0) |=> (y_q == '0));

endmodule

// File: rtl/qmod_mixer.sv
module qmod_mixer #(
  parameter int FW    = 28,
  parameter int CRW   = 12,
  parameter int OW    = 16,
  parameter int SHIFT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [FW-1:0]  fir_i,
  input  logic signed [FW-1:0]  fir_q,
  input  logic signed [CRW-1:0] car_cos,
  input  logic signed [CRW-1:0] car_sin,
  output logic signed [OW-1:0]  if_out
);
  localparam int PW = FW + CRW;
  localparam logic signed [PW:0] HALF = (PW+1)'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [PW:0] OMAX = (PW+1)'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [PW:0] OMIN = -OMAX - (PW+1)'(1);

  logic signed [PW:0]   mix;
  logic signed [PW:0]   rnd;
  logic signed [PW:0]   shr;
  logic signed [OW-1:0] sat;

  always_comb begin
    mix = (PW+1)'(fir_i) * (PW+1)'(car_cos) - (PW+1)'(fir_q) * (PW+1)'(car_sin);
    rnd = mix + HALF;
    shr = rnd >>> SHIFT;
    if (shr > OMAX)      sat = OW'(OMAX);
    else if (shr < OMIN) sat = OW'(OMIN);
    else                 sat = OW'(shr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) if_out <= '0;
    else        if_out <= sat;
  end

  p_no_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (car_cos == '0 && car_sin == '0) |=> (if_out == '0));

  p_zero_fir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fir_i == '0 && fir_q == '0) |=> (if_out == '0));

endmodule

// File: rtl/qpsk_if_modulator.sv
module qpsk_if_modulator #(
  parameter int INTERP = 4,
  parameter int TAPS   = 60,
  parameter int CW     = 12,
  parameter int DW     = 10,
  parameter int AMP    = 511,
  parameter int CRW    = 12,
  parameter int OW     = 16,
  parameter int SHIFT  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid,
  output logic                  sym_ready,
  input  logic [1:0]            sym_bits,
  input  logic signed [CRW-1:0] car_cos,
  input  logic signed [CRW-1:0] car_sin,
  output logic signed [OW-1:0]  if_out
);
  localparam int FW = CW + $clog2(TAPS) + DW;

  logic [1:0]           nz;
  logic [1:0]           neg;
  logic signed [FW-1:0] fir [2];

  qmod_mapper #(.INTERP(INTERP)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_bits  (sym_bits),
    .i_nz      (nz[0]),
    .i_neg     (neg[0]),
    .q_nz      (nz[1]),
    .q_neg     (neg[1])
  );

  // Index 0 is the in-phase rail, index 1 the quadrature rail.
  generate
    for (genvar g = 0; g < 2; g++) begin : g_rail
      qmod_interp_fir #(.TAPS(TAPS), .CW(CW), .DW(DW), .AMP(AMP)) u_fir (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_nz  (nz[g]),
        .in_neg (neg[g]),
        .y_q    (fir[g])
      );
    end
  endgenerate

  qmod_mixer #(.FW(FW), .CRW(CRW), .OW(OW), .SHIFT(SHIFT)) u_mix (
    .clk     (clk),
    .rst_n   (rst_n),
    .fir_i   (fir[0]),
    .fir_q   (fir[1]),
    .car_cos (car_cos),
    .car_sin (car_sin),
    .if_out  (if_out)
  );

endmodule

// File: tb/test_qpsk_if_modulator.sv
module test_qpsk_if_modulator;
  localparam int L    = 4;
  localparam int N    = 60;
  localparam int AMPV = 511;
  localparam int SH   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sym_valid = 1'b0;
  logic              sym_ready;
  logic [1:0]        sym_bits = 2'b00;
  logic signed [11:0] car_cos = '0;
  logic signed [11:0] car_sin = '0;
  logic signed [15:0] if_out;

  always #2 clk = ~clk;

  qpsk_if_modulator i_qpsk_if_modulator (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_bits(sym_bits), .car_cos(car_cos), .car_sin(car_sin), .if_out(if_out)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int sat_hits_hi = 0;
  int sat_hits_lo = 0;

  // Reference pulse table (R5): centre outward, mirrored on both sides.
  int half_tab [30] = '{1750, 1410, 850, 250, -195, -385, -325, -117, 103, 223,
                        202, 76, -65, -140, -125, -50, 40, 95, 85, 30,
                        -20, -60, -50, -15, 10, 30, 25, 8, -3, -10};

  function automatic int cof(input int k);
    return (k < N/2) ? half_tab[N/2 - 1 - k] : half_tab[k - N/2];
  endfunction

  // Behavioural model state
  int     hist_i [$];
  int     hist_q [$];
  longint m_fi, m_fq, m_out;
  int     m_ph;

  task automatic model_clear();
    hist_i = {};
    hist_q = {};
    for (int k = 0; k < N; k++) begin
      hist_i.push_back(0);
      hist_q.push_back(0);
    end
    m_fi = 0; m_fq = 0; m_out = 0; m_ph = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      model_clear();
    end else begin
      longint v;
      longint r;
      longint si;
      longint sq;
      // R6: mixer output from filter values held before this edge
      v = m_fi * longint'(car_cos) - m_fq * longint'(car_sin);
      r = (v + (64'sd1 <<< (SH - 1))) >>> SH;
      if (r > 32767) begin r = 32767; sat_hits_hi++; end
      else if (r < -32768) begin r = -32768; sat_hits_lo++; end
      m_out = r;
      // R5: filter sums over the history before this edge
      si = 0; sq = 0;
      for (int k = 0; k < N; k++) begin
        si += longint'(cof(k)) * hist_i[k];
        sq += longint'(cof(k)) * hist_q[k];
      end
      m_fi = si * AMPV;
      m_fq = sq * AMPV;
      // R2/R3/R4: one new sample per rail, symbol only on a handshake
      if (sym_valid && m_ph == 0) begin
        hist_i.push_front(sym_bits[0] ? -1 : 1);
        hist_q.push_front(sym_bits[1] ? -1 : 1);
      end else begin
        hist_i.push_front(0);
        hist_q.push_front(0);
      end
      void'(hist_i.pop_back());
      void'(hist_q.pop_back());
      m_ph = (m_ph + 1) % L;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One clock; compare against the model away from the edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R5 R6 if_out", longint'(if_out), m_out);
    check("R3 sym_ready", longint'(sym_ready), longint'(m_ph == 0));
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic fs4_carrier(input int n);
    case (n % 4)
      0: begin car_cos = 12'sd2047;  car_sin = 12'sd0;     end
      1: begin car_cos = 12'sd0;     car_sin = 12'sd2047;  end
      2: begin car_cos = -12'sd2047; car_sin = 12'sd0;     end
      default: begin car_cos = 12'sd0; car_sin = -12'sd2047; end
    endcase
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state, with inputs active
    car_cos = 12'sd2047;
    sym_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 if_out in reset", longint'(if_out), 0);
    check("R1 ready in reset", longint'(sym_ready), 1);
    sym_valid = 1'b0;
    rst_n = 1'b1;

    // R4: idle after reset keeps output at zero
    for (int n = 0; n < 12; n++) begin
      step();
      check("R4 idle zero", longint'(if_out), 0);
    end

    // R7 and R2: one isolated symbol, carrier cos only
    car_cos = 12'sd2047; car_sin = 12'sd0;
    while (!sym_ready) step();
    sym_valid = 1'b1; sym_bits = 2'b00;
    step();                              // handshake edge k
    sym_valid = 1'b0;
    check("R7 no output after k", longint'(if_out), 0);
    step();                              // edge k+1
    check("R7 no output after k+1", longint'(if_out), 0);
    step();                              // edge k+2
    check("R7 output after k+2", longint'(if_out != 0), 1);
    check("R2 +AMP on edge tap is negative", longint'(if_out < 0), 1);
    for (int n = 0; n < 30; n++) step();

    // R2: single symbol with I negative, Q positive, sine carrier only
    car_cos = 12'sd0; car_sin = 12'sd2047;
    while (!sym_ready) step();
    sym_valid = 1'b1; sym_bits = 2'b01;
    step();
    sym_valid = 1'b0;
    for (int n = 0; n < 80; n++) step();
    check("R4 flushed to zero", longint'(if_out), 0);

    // Main stream: quarter-rate carrier, gaps, bits changing while not ready (R3)
    for (int n = 0; n < 1200; n++) begin
      fs4_carrier(n);
      lfsr_step();
      sym_valid = (lfsr[1:0] != 2'b00);
      sym_bits  = lfsr[5:4];
      step();
    end

    // R6: saturation at both ends with a diagonal carrier
    sym_valid = 1'b1;
    sym_bits  = 2'b10;
    car_cos = 12'sd2047; car_sin = 12'sd2047;
    for (int n = 0; n < 200; n++) step();
    sym_bits = 2'b01;
    for (int n = 0; n < 200; n++) step();
    check("R6 positive clip reached", longint'(sat_hits_hi > 0), 1);
    check("R6 negative clip reached", longint'(sat_hits_lo > 0), 1);

    // R6: zero carrier with live data gives zero output
    car_cos = 12'sd0; car_sin = 12'sd0;
    for (int n = 0; n < 20; n++) begin
      lfsr_step();
      sym_bits = lfsr[3:2];
      step();
      if (n > 0) check("R6 zero carrier", longint'(if_out), 0);
    end

    // R4: stop supplying symbols, output must settle to zero
    sym_valid = 1'b0;
    car_cos = 12'sd1500; car_sin = -12'sd900;
    for (int n = 0; n < 80; n++) step();
    check("R4 final flush", longint'(if_out), 0);

    finish_run();
  end

endmodule